// File: doc/BRIEF.md
# Hit Packet Builder

This block turns one detected hit on a single detector channel into a framed packet. It writes the packet one word per cycle into a downstream data FIFO. A small control machine walks through a fixed order. First come two metadata words that carry the hit class, the channel number and the timestamp captured when the hit began. Next come the raw sample words of the hit. Last comes one closing metadata word with the number of samples written and a flag that marks a cut-short packet. A select line beside every written word tells metadata (9 significant bits) apart from sample words (10 bits). A one-cycle pulse to a second, separate FIFO records the start time of every packet.

Samples arrive on a valid strobe and wait in a small input buffer until the header has gone out. A free-running 12-bit sample clock counter supplies the timestamp. Both downstream FIFOs report almost-full. If either one is almost full when a hit begins, the whole hit is refused and counted. If the data FIFO becomes almost full while samples are being written, the packet is cut short and closed at once.

Top module: `hit_packet_builder`

## Requirements
- R1: `ts_now` is 0 during reset, rises by one on every clock edge after reset and wraps from 4095 to 0.
- R2: A `hit_start` accepted in idle produces, on consecutive write cycles, header word A = {hit_type[1:0], chan_id[4:0], ts[11:10]}, then header word B = ts[9:1], then the payload, then the closing word. The next cycle after the closing word has no write. `ts` is the value of `ts_now` in the `hit_start` cycle. Type and channel are taken in that same cycle.
- R3: Metadata words are written with `out_sel`=0 and `out_word[9]`=0. Sample words are written with `out_sel`=1, carry the sample value unchanged and keep their arrival order.
- R4: A sample is taken when `smp_valid` is high in any cycle after the accepted `hit_start` cycle, up to and including the `hit_done` cycle. Samples in the `hit_start` cycle or after `hit_done` are ignored.
- R5: The closing word is {ts[0], trunc, 1'b0, count[5:0]}. For a complete hit, trunc is 0 and count is the number of sample words written.
- R6: Each accepted packet gives exactly one `sof_we` pulse, in the same cycle as header word A, with `sof_ts` equal to the captured timestamp.
- R7: A `hit_start` in idle while `out_afull` or `sof_afull` is high writes nothing to either FIFO and raises `drop_count` by one.
- R8: A `hit_start` while a packet is in progress leaves that packet unchanged and raises `drop_count` by one.
- R9: No sample word is written in a cycle where `out_afull` is high. If `out_afull` rises during the payload, the packet closes with trunc=1 and a count equal to the sample words written, which are the first samples of the hit.
- R10: At most 63 sample words are written. After the 63rd the packet closes, with trunc=1 only if more samples of the hit were pending.
- R11: During reset `out_we`, `sof_we` and `drop_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_start | input | 1 | One-cycle pulse: a hit begins |
| hit_type | input | 2 | Hit class, taken with `hit_start` |
| chan_id | input | 5 | Channel number, taken with `hit_start` |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 10 | Sample value |
| hit_done | input | 1 | Marks the last sample cycle of the hit |
| out_afull | input | 1 | Data FIFO almost full |
| sof_afull | input | 1 | Start-of-frame FIFO almost full |
| out_we | output | 1 | Data FIFO write strobe |
| out_sel | output | 1 | 0: metadata word, 1: sample word |
| out_word | output | 10 | Word written to the data FIFO |
| sof_we | output | 1 | Start-of-frame FIFO write strobe |
| sof_ts | output | 12 | Packet start timestamp for the start-of-frame FIFO |
| drop_count | output | 8 | Refused hits, wrapping |
| ts_now | output | 12 | Running sample timestamp |

## Verification
Some properties are checked on every cycle. The timestamp steps by one. Sample words are never written under almost-full. Metadata words keep their top bit clear. The input buffer never overflows or underflows. Each refused start bumps the drop counter. The start-of-frame strobe is a single pulse. A closing word is never followed by a write. The packet count stays below its limit. Other properties can only be shown by the bench's scenarios, because they depend on the word order of a whole packet. These are the exact header and closing word contents, the capture window of the samples, and the packets cut short by almost-full or by the 63-sample limit.

// File: rtl/hpb_pkg.sv
`timescale 1ns/1ps
package hpb_pkg;
  localparam int TS_W    = 12;
  localparam int CNT_W   = 6;
  localparam int META_W  = 9;
  localparam int SMP_W   = 10;
  localparam int TYPE_W  = 2;
  localparam int CHAN_W  = 5;
  localparam int MAX_SMP = (1 << CNT_W) - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDRA, ST_HDRB, ST_PAY, ST_CLOSE
  } hpb_state_e;

  // header word A: class, channel, timestamp top bits
  function automatic logic [META_W-1:0] mk_hdr_a(logic [TYPE_W-1:0] ty,
                                                 logic [CHAN_W-1:0] ch,
                                                 logic [TS_W-1:0] ts);
    return {ty, ch, ts[TS_W-1:TS_W-2]};
  endfunction

  // header word B: timestamp middle bits
  function automatic logic [META_W-1:0] mk_hdr_b(logic [TS_W-1:0] ts);
    return ts[TS_W-3:1];
  endfunction

  // closing word: timestamp lsb, truncation flag, spare, count
  function automatic logic [META_W-1:0] mk_close(logic [TS_W-1:0] ts, logic trunc,
                                                 logic [CNT_W-1:0] cnt);
    return {ts[0], trunc, 1'b0, cnt};
  endfunction

  function automatic logic is_last_slot(logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(MAX_SMP - 1);
  endfunction
endpackage

// File: rtl/hpb_ts_counter.sv
`timescale 1ns/1ps
module hpb_ts_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] ts
);
  always_ff @(posedge clk) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts == W'($past(ts) + 1'b1)); // R1
endmodule

// File: rtl/hpb_sample_fifo.sv
`timescale 1ns/1ps
module hpb_sample_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8,   // power of two
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wr_data,
  input  logic          pop,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [LW-1:0] wptr, rptr;

  assign level   = wptr - rptr;
  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign rd_data = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wptr[AW-1:0]] <= wr_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3
endmodule

// File: rtl/hpb_data_selector.sv
`timescale 1ns/1ps
module hpb_data_selector #(
  parameter int META_W = 9,
  parameter int SMP_W  = 10
) (
  input  logic              sel,
  input  logic [META_W-1:0] meta,
  input  logic [SMP_W-1:0]  smp,
  output logic [SMP_W-1:0]  word
);
  assign word = sel ? smp : SMP_W'(meta);
endmodule

// File: rtl/hit_packet_builder.sv
`timescale 1ns/1ps
module hit_packet_builder
  import hpb_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DROP_W     = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_start,
  input  logic [TYPE_W-1:0] hit_type,
  input  logic [CHAN_W-1:0] chan_id,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              hit_done,
  input  logic              out_afull,
  input  logic              sof_afull,
  output logic              out_we,
  output logic              out_sel,
  output logic [SMP_W-1:0]  out_word,
  output logic              sof_we,
  output logic [TS_W-1:0]   sof_ts,
  output logic [DROP_W-1:0] drop_count,
  output logic [TS_W-1:0]   ts_now
);
  hpb_state_e          state;
  logic                capture, trunc;
  logic [CNT_W-1:0]    cnt;
  logic [TYPE_W-1:0]   ty_lat;
  logic [CHAN_W-1:0]   ch_lat;
  logic [TS_W-1:0]     ts_lat;
  logic [META_W-1:0]   meta_word;
  logic [SMP_W-1:0]    head_smp;
  logic                buf_empty, buf_full;
  logic [LVL_W-1:0]    buf_level;

  // named internal events
  logic start_ok, start_drop, pay_write, close_write, hdr_write, more_pending;
  assign start_ok     = (state == ST_IDLE) && hit_start && !out_afull && !sof_afull;
  assign start_drop   = hit_start && !start_ok;
  assign pay_write    = (state == ST_PAY) && !out_afull && !buf_empty;
  assign close_write  = (state == ST_CLOSE);
  assign hdr_write    = (state == ST_HDRA) || (state == ST_HDRB);
  assign more_pending = capture || (buf_level > LVL_W'(1));

  hpb_ts_counter #(.W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .ts(ts_now)
  );

  hpb_sample_fifo #(.W(SMP_W), .DEPTH(FIFO_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(close_write),
    .push(capture && smp_valid), .wr_data(smp_data),
    .pop(pay_write), .rd_data(head_smp),
    .empty(buf_empty), .full(buf_full), .level(buf_level)
  );

  always_comb begin
    case (state)
      ST_HDRA: meta_word = mk_hdr_a(ty_lat, ch_lat, ts_lat);
      ST_HDRB: meta_word = mk_hdr_b(ts_lat);
      default: meta_word = mk_close(ts_lat, trunc, cnt);
    endcase
  end

  hpb_data_selector #(.META_W(META_W), .SMP_W(SMP_W)) u_sel (
    .sel(pay_write), .meta(meta_word), .smp(head_smp), .word(out_word)
  );

  assign out_we  = hdr_write || pay_write || close_write;
  assign out_sel = pay_write;
  assign sof_we  = (state == ST_HDRA);
  assign sof_ts  = ts_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      capture    <= 1'b0;
      trunc      <= 1'b0;
      cnt        <= '0;
      ty_lat     <= '0;
      ch_lat     <= '0;
      ts_lat     <= '0;
      drop_count <= '0;
    end else begin
      if (start_drop) drop_count <= drop_count + 1'b1;
      if (hit_done || close_write) capture <= 1'b0;
      case (state)
        ST_IDLE: if (start_ok) begin
          ty_lat  <= hit_type;
          ch_lat  <= chan_id;
          ts_lat  <= ts_now;
          capture <= 1'b1;
          cnt     <= '0;
          trunc   <= 1'b0;
          state   <= ST_HDRA;
        end
        ST_HDRA: state <= ST_HDRB;
        ST_HDRB: state <= ST_PAY;
        ST_PAY: begin
          if (!capture && buf_empty) begin
            state <= ST_CLOSE;
          end else if (out_afull) begin
            trunc   <= 1'b1;
            capture <= 1'b0;
            state   <= ST_CLOSE;
          end else if (!buf_empty) begin
            cnt <= cnt + 1'b1;
            if (is_last_slot(cnt)) begin
              trunc   <= more_pending;
              capture <= 1'b0;
              state   <= ST_CLOSE;
            end
          end
        end
        ST_CLOSE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_NO_SAMPLE_AFULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && out_sel) |-> !out_afull); // R9
  AST_META_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && !out_sel) |-> (out_word[SMP_W-1] == 1'b0)); // R3
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> drop_count == DROP_W'($past(drop_count) + 1'b1)); // R7
  AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_we |=> !sof_we); // R6
  AST_CLOSE_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    close_write |=> !out_we); // R2
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pay_write |-> (cnt != CNT_W'(MAX_SMP))); // R10
endmodule

// File: tb/hit_packet_builder_test.sv
`timescale 1ns/1ps
module hit_packet_builder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, hit_start, smp_valid, hit_done, out_afull, sof_afull;
  logic [1:0]  hit_type;
  logic [4:0]  chan_id;
  logic [9:0]  smp_data;
  logic        out_we, out_sel, sof_we;
  logic [9:0]  out_word;
  logic [11:0] sof_ts, ts_now;
  logic [7:0]  drop_count;

  hit_packet_builder uut (
    .clk(clk), .rst_n(rst_n), .hit_start(hit_start), .hit_type(hit_type),
    .chan_id(chan_id), .smp_valid(smp_valid), .smp_data(smp_data),
    .hit_done(hit_done), .out_afull(out_afull), .sof_afull(sof_afull),
    .out_we(out_we), .out_sel(out_sel), .out_word(out_word), .sof_we(sof_we),
    .sof_ts(sof_ts), .drop_count(drop_count), .ts_now(ts_now)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [10:0] wq[$];
  logic [11:0] sq[$];
  logic [9:0]  exp_smp[$];
  int bad_ts = 0, bad_afull = 0;
  logic [11:0] prev_ts;
  bit have_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected words, as integers with the select bit at weight 1024
  function automatic int exp_hdr_a(int ty, int ch, int ts);
    return ty * 128 + ch * 4 + ts / 1024;
  endfunction
  function automatic int exp_hdr_b(int ts);
    return (ts % 1024) / 2;
  endfunction
  function automatic int exp_close(int ts, int tr, int n);
    return (ts % 2) * 256 + tr * 128 + n;
  endfunction

  // monitor, sampling mid-cycle
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n) begin
      if (out_we) wq.push_back({out_sel, out_word});
      if (sof_we) sq.push_back(sof_ts);
      if (out_we && out_sel && out_afull) bad_afull++;
      if (have_prev && ts_now != prev_ts + 12'd1) bad_ts++;
      prev_ts   = ts_now;
      have_prev = 1'b1;
    end
  end

  task automatic drive_hit(input logic [1:0] ty, input logic [4:0] ch, input int n,
                           input int gap_pct, input int extra_at, output int ts_o);
    exp_smp.delete();
    @(negedge clk);
    hit_start = 1'b1; hit_type = ty; chan_id = ch;
    smp_valid = 1'b1; smp_data = 10'h3A5;           // R4: ignored junk
    ts_o = int'(ts_now);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hit_start = 1'b0; hit_type = ~ty; chan_id = ~ch;
      smp_valid = 1'b0; hit_done = 1'b0;
      if (int'($urandom_range(99)) < gap_pct) @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 10'($urandom_range(1023));
      exp_smp.push_back(smp_data);
      hit_done  = (i == n - 1);
      hit_start = (i == extra_at);
    end
    @(negedge clk);
    hit_done = 1'b0; hit_start = 1'b0;
    smp_valid = 1'b1; smp_data = 10'h15A;           // R4: after done, ignored
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic check_packet(input int ty, input int ch, input int ts,
                              input int n, input int tr);
    chk(wq.size() == n + 3, "R2 packet length", wq.size(), n + 3);
    if (wq.size() == n + 3) begin
      chk(int'(wq[0]) == exp_hdr_a(ty, ch, ts), "R2 header A", int'(wq[0]), exp_hdr_a(ty, ch, ts));
      chk(int'(wq[1]) == exp_hdr_b(ts), "R2 header B", int'(wq[1]), exp_hdr_b(ts));
      for (int i = 0; i < n; i++)
        chk(int'(wq[2 + i]) == 1024 + int'(exp_smp[i]), "R3 R4 sample word",
            int'(wq[2 + i]), 1024 + int'(exp_smp[i]));
      chk(int'(wq[n + 2]) == exp_close(ts, tr, n), "R5 R10 closing word",
          int'(wq[n + 2]), exp_close(ts, tr, n));
    end
    chk(sq.size() == 1, "R6 sof count", sq.size(), 1);
    if (sq.size() == 1) chk(int'(sq[0]) == ts, "R6 sof timestamp", int'(sq[0]), ts);
    wq.delete(); sq.delete();
  endtask

  initial begin
    int ts, d0, nsmp, last;
    rst_n = 1'b0; hit_start = 1'b0; hit_type = '0; chan_id = '0;
    smp_valid = 1'b0; smp_data = '0; hit_done = 1'b0;
    out_afull = 1'b0; sof_afull = 1'b0;
    void'($urandom(32'd20231));
    repeat (4) @(negedge clk);
    #1.5;
    chk(out_we == 1'b0, "R11 reset out_we", int'(out_we), 0);
    chk(sof_we == 1'b0, "R11 reset sof_we", int'(sof_we), 0);
    chk(drop_count == 8'd0, "R11 reset drop_count", int'(drop_count), 0);
    chk(ts_now == 12'd0, "R1 reset timestamp", int'(ts_now), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed: plain hit
    drive_hit(2'd2, 5'd5, 8, 0, -1, ts); settle();
    check_packet(2, 5, ts, 8, 0);
    // R10: exactly at the limit, nothing pending
    drive_hit(2'd1, 5'd30, 63, 0, -1, ts); settle();
    check_packet(1, 30, ts, 63, 0);
    // R10: beyond the limit
    drive_hit(2'd3, 5'd1, 70, 0, -1, ts); settle();
    check_packet(3, 1, ts, 63, 1);
    // R8: start while busy
    d0 = int'(drop_count);
    drive_hit(2'd1, 5'd17, 12, 0, 3, ts); settle();
    check_packet(1, 17, ts, 12, 0);
    chk(int'(drop_count) == (d0 + 1) % 256, "R8 busy start counted", int'(drop_count), (d0 + 1) % 256);
    // R7: refused by data almost-full
    d0 = int'(drop_count);
    @(negedge clk); out_afull = 1'b1;
    drive_hit(2'd3, 5'd9, 5, 0, -1, ts); settle();
    out_afull = 1'b0;
    chk(wq.size() == 0 && sq.size() == 0, "R7 refused hit writes nothing", wq.size() + sq.size(), 0);
    chk(int'(drop_count) == (d0 + 1) % 256, "R7 drop on out_afull", int'(drop_count), (d0 + 1) % 256);
    wq.delete(); sq.delete();
    // R7: refused by start-of-frame almost-full
    d0 = int'(drop_count);
    @(negedge clk); sof_afull = 1'b1;
    drive_hit(2'd0, 5'd22, 6, 0, -1, ts); settle();
    sof_afull = 1'b0;
    chk(wq.size() == 0 && sq.size() == 0, "R7 refused hit writes nothing", wq.size() + sq.size(), 0);
    chk(int'(drop_count) == (d0 + 1) % 256, "R7 drop on sof_afull", int'(drop_count), (d0 + 1) % 256);
    wq.delete(); sq.delete();
    // R9: almost-full in the middle of the payload
    fork
      drive_hit(2'd0, 5'd3, 30, 0, -1, ts);
      begin
        while (wq.size() < 12) @(negedge clk);
        @(negedge clk); out_afull = 1'b1;
        repeat (10) @(negedge clk);
        out_afull = 1'b0;
      end
    join
    settle();
    nsmp = wq.size() - 3;
    last = (wq.size() > 0) ? int'(wq[wq.size() - 1]) : 0;
    chk(((last / 128) % 2) == 1, "R9 trunc flag", (last / 128) % 2, 1);
    chk((last % 64) == nsmp, "R9 count matches words", last % 64, nsmp);
    chk(nsmp >= 10 && nsmp < 30, "R9 payload cut short", nsmp, 10);
    if (wq.size() >= 3) begin
      chk(int'(wq[0]) == exp_hdr_a(0, 3, ts), "R9 header A", int'(wq[0]), exp_hdr_a(0, 3, ts));
      for (int i = 0; i < nsmp && i < 30; i++)
        chk(int'(wq[2 + i]) == 1024 + int'(exp_smp[i]), "R9 sample prefix",
            int'(wq[2 + i]), 1024 + int'(exp_smp[i]));
    end
    chk(bad_afull == 0, "R9 no sample under almost-full", bad_afull, 0);
    wq.delete(); sq.delete();

    // constrained random hits
    for (int k = 0; k < 16; k++) begin
      int rty, rch, rn;
      rty = int'($urandom_range(3));
      rch = int'($urandom_range(31));
      rn  = 1 + int'($urandom_range(40));
      drive_hit(2'(rty), 5'(rch), rn, 30, -1, ts); settle();
      check_packet(rty, rch, ts, rn, 0);
    end

    // R1: wrap of the timestamp
    while (ts_now != 12'd4095) @(negedge clk);
    @(negedge clk); #1.5;
    chk(ts_now == 12'd0, "R1 timestamp wrap", int'(ts_now), 0);
    chk(bad_ts == 0, "R1 timestamp steps by one", bad_ts, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule